// File: doc/BRIEF.md
# BCD Real-Time Clock Register Port

This block is a calendar clock whose sixteen 4-bit registers a host reaches through three byte registers. The registers hold BCD digits for seconds, minutes, hours, day of month, month and year, plus a day-of-week count and three control nibbles. A one-second pulse on `sec_tick` advances the time. The control nibbles select a frozen host view, stopped counting, cleared seconds, and 12- or 24-hour format.

The host selects a register with `bus_sel` and strobes `bus_wr` or `bus_rd`. Selector 0 is the enable register. Selector 1 is the shared port. Selector 2 is the status register.

Once the port is enabled, the first byte written to the shared port is a command. The next byte sets a register index. Every read or write after that touches the indexed register and then moves the index on by one. Time digits that the host reads come from a shadow copy. The shadow copy can be held still while the real count keeps running.

Top module: `bcd_rtc_port`

## Requirements
- R1: Bit 0 of a write to the enable register (selector 0) turns the port on (1) or off (0). A read of selector 0 returns 0x01 when the port is on and 0x00 when it is off. A shared-port read while the port is off, or before an index is set, returns 0x00.
- R2: After the port is turned on, a shared-port write of 0x03 or 0x0C is accepted as the command and moves the port to the index step. Any other byte written at that step is ignored, and the port keeps waiting for a command.
- R3: The write after an accepted command loads the register index from bits 3:0. Each later shared-port read or write accesses that register and then increments the index modulo 16, so index 15 is followed by index 0. A write stores bits 3:0. A read returns the nibble in bits 3:0 with bits 7:4 zero.
- R4: The register map is fixed as follows. Index 0 and 1 are the seconds ones and tens digits. Index 2 and 3 are the minutes ones and tens. Index 4 and 5 are the hours ones and tens. Index 6 and 7 are the day ones and tens. Index 8 and 9 are the month ones and tens. Index 10 and 11 are the year ones and tens. Index 12 is the day of week (0-6). Index 13, 14 and 15 are control nibbles A, B and C. After reset, day ones = 1 and month ones = 1, all other time digits are 0, and A/B/C = 0x1/0xF/0x6.
- R5: Each `sec_tick` pulse, while the clock is running, adds one second. BCD carries ripple through minutes (00-59), hours, day, month (1-12) and year. The day of week steps with the day and wraps from 6 to 0.
- R6: The day rolls over after 28, 30 or 31 days as the month requires. February has 29 days when the year value is a multiple of 4. The year wraps from 99 to 00.
- R7: With bit 2 of control C clear, hours run 1-12 and bit 2 of the hours-tens digit is the PM flag (1 = PM). 11 rolls to 12 and toggles the flag. The day advances only when 11 PM rolls to 12 AM. With bit 2 set, hours run 00-23.
- R8: While bit 0 of control A is set, the time digits that the host reads stay fixed, but the internal count keeps advancing. One cycle after the bit is cleared, reads show the internal count.
- R9: While bit 1 of control C is set, ticks do not change the time.
- R10: While bit 0 of control C is set, ticks do not change the time, and both seconds digits are held at 0.
- R11: Bit 7 of the status register (selector 2) is 1 when the port is at the data step. It reads 0 in the cycle after a shared-port data read. All other status bits read 0, and bit 7 reads 0 outside the data step.
- R12: Turning the port off returns the sequencer to its start. After the port is turned back on, the next shared-port write is treated as a command again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_sel | input | 2 | Register select: 0 enable, 1 shared port, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; the data on bus_rdata is valid in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |

## Verification
The assertions assume three things about the inputs. The host issues at most one of `bus_wr` or `bus_rd` per cycle. No host write to a time digit lands in the same cycle as a tick, because in that cycle the write wins and the tick is dropped. Digits written into the time registers are legal BCD for their field. The stimulus keeps to these rules by issuing ticks from their own task, on cycles with no bus activity, and by loading only valid times. It reads the shadow digits only after the cycle in which they follow the internal count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W = 4;
  localparam int NTIME = 13;
  localparam int NREG  = 16;
  localparam int IDX_W = $clog2(NREG);
  localparam int BUS_W = 8;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [NTIME-1:0][NIB_W-1:0] tbank_t;
  typedef enum logic [1:0] {PH_OFF, PH_CMD, PH_IDX, PH_DATA} phase_t;

  localparam logic [IDX_W-1:0] R_S1  = 4'd0;
  localparam logic [IDX_W-1:0] R_S10 = 4'd1;
  localparam logic [IDX_W-1:0] R_M1  = 4'd2;
  localparam logic [IDX_W-1:0] R_M10 = 4'd3;
  localparam logic [IDX_W-1:0] R_H1  = 4'd4;
  localparam logic [IDX_W-1:0] R_H10 = 4'd5;
  localparam logic [IDX_W-1:0] R_D1  = 4'd6;
  localparam logic [IDX_W-1:0] R_D10 = 4'd7;
  localparam logic [IDX_W-1:0] R_MO1 = 4'd8;
  localparam logic [IDX_W-1:0] R_MO10= 4'd9;
  localparam logic [IDX_W-1:0] R_Y1  = 4'd10;
  localparam logic [IDX_W-1:0] R_Y10 = 4'd11;
  localparam logic [IDX_W-1:0] R_DOW = 4'd12;
  localparam logic [IDX_W-1:0] R_CA  = 4'd13;
  localparam logic [IDX_W-1:0] R_CB  = 4'd14;

  localparam logic [1:0] SEL_EN   = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam logic [BUS_W-1:0] CMD_SEQ_A = 8'h03;
  localparam logic [BUS_W-1:0] CMD_SEQ_B = 8'h0C;

  localparam nib_t CA_RST = 4'h1;
  localparam nib_t CB_RST = 4'hF;
  localparam nib_t CC_RST = 4'h6;
  localparam nib_t DOW_LAST = 4'd6;

  function automatic tbank_t epoch_bank();
    tbank_t b;
    b = '0;
    b[R_D1]  = 4'd1;
    b[R_MO1] = 4'd1;
    return b;
  endfunction

  function automatic logic [6:0] bcd2bin(input nib_t tens, input nib_t ones);
    return ({3'b000, tens} * 7'd10) + {3'b000, ones};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    nib_t q, r;
    q = 4'(v / 7'd10);
    r = 4'(v % 7'd10);
    return {q, r};
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2:                       return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  function automatic tbank_t rtc_advance(input tbank_t t, input logic h24);
    tbank_t n;
    logic [6:0] sec, mn, hr, dy, mo, yr;
    logic [7:0] b;
    nib_t dw;
    logic pm, carry_day;
    n   = t;
    sec = bcd2bin(t[R_S10], t[R_S1]);
    mn  = bcd2bin(t[R_M10], t[R_M1]);
    hr  = h24 ? bcd2bin(t[R_H10], t[R_H1]) : bcd2bin({2'b00, t[R_H10][1:0]}, t[R_H1]);
    pm  = t[R_H10][2];
    dy  = bcd2bin(t[R_D10], t[R_D1]);
    mo  = bcd2bin(t[R_MO10], t[R_MO1]);
    yr  = bcd2bin(t[R_Y10], t[R_Y1]);
    dw  = t[R_DOW];
    carry_day = 1'b0;
    if (sec != 7'd59) sec = sec + 7'd1;
    else begin
      sec = '0;
      if (mn != 7'd59) mn = mn + 7'd1;
      else begin
        mn = '0;
        if (h24) begin
          if (hr != 7'd23) hr = hr + 7'd1;
          else begin
            hr = '0;
            carry_day = 1'b1;
          end
        end else if (hr == 7'd11) begin
          hr = 7'd12;
          carry_day = pm;
          pm = !pm;
        end else if (hr == 7'd12) hr = 7'd1;
        else hr = hr + 7'd1;
      end
    end
    if (carry_day) begin
      dw = (dw >= DOW_LAST) ? '0 : dw + 4'd1;
      if (dy < days_in_month(mo, yr)) dy = dy + 7'd1;
      else begin
        dy = 7'd1;
        if (mo < 7'd12) mo = mo + 7'd1;
        else begin
          mo = 7'd1;
          yr = (yr >= 7'd99) ? '0 : yr + 7'd1;
        end
      end
    end
    b = bin2bcd(sec); n[R_S10] = b[7:4]; n[R_S1] = b[3:0];
    b = bin2bcd(mn);  n[R_M10] = b[7:4]; n[R_M1] = b[3:0];
    b = bin2bcd(hr);  n[R_H1]  = b[3:0];
    n[R_H10] = h24 ? b[7:4] : {1'b0, pm, b[5:4]};
    b = bin2bcd(dy);  n[R_D10] = b[7:4]; n[R_D1] = b[3:0];
    b = bin2bcd(mo);  n[R_MO10] = b[7:4]; n[R_MO1] = b[3:0];
    b = bin2bcd(yr);  n[R_Y10] = b[7:4]; n[R_Y1] = b[3:0];
    n[R_DOW] = dw;
    return n;
  endfunction
endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stop,
  input  logic             clr_sec,
  input  logic             h24,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  nib_t             wr_nib,
  output tbank_t           time_q,
  output logic             step
);
  assign step = tick && !stop && !clr_sec && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= epoch_bank();
    end else begin
      if (wr_en) time_q[wr_idx] <= wr_nib;
      else if (step) time_q <= rtc_advance(time_q, h24);
      if (clr_sec) begin
        time_q[R_S1]  <= '0;
        time_q[R_S10] <= '0;
      end
    end
  end

  // R5
  tick_moves_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> time_q != $past(time_q));

  // R9
  stop_holds_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable(time_q[NTIME-1:2]));

  // R10
  clear_secs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sec |=> (time_q[R_S1] == '0 && time_q[R_S10] == '0));
endmodule

// File: rtl/rtc_port_seq.sv
module rtc_port_seq
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic [BUS_W-1:0] wdata,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic             ready
);
  logic acc;
  logic rd_hit;
  logic rd_flag;
  logic cmd_ok;

  assign acc    = (data_wr || data_rd) && phase == PH_DATA && !en_wr;
  assign rd_hit = data_rd && phase == PH_DATA;
  assign cmd_ok = (wdata == CMD_SEQ_A) || (wdata == CMD_SEQ_B);
  assign ready  = (phase == PH_DATA) && !rd_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_OFF;
      idx     <= '0;
      rd_flag <= 1'b0;
    end else begin
      rd_flag <= rd_hit;
      if (en_wr) begin
        if (!wdata[0]) phase <= PH_OFF;
        else if (phase == PH_OFF) phase <= PH_CMD;
      end else if (acc) begin
        idx <= idx + 1'b1;
      end else if (data_wr) begin
        case (phase)
          PH_CMD: if (cmd_ok) phase <= PH_IDX;
          PH_IDX: begin
            idx   <= wdata[IDX_W-1:0];
            phase <= PH_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> idx == $past(idx) + 1'b1);

  // R12
  disable_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !wdata[0]) |=> phase == PH_OFF);

  // R11
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> !ready);
endmodule

// File: rtl/bcd_rtc_port.sv
module bcd_rtc_port
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata
);
  logic en_wr, data_wr, data_rd;
  phase_t phase;
  logic [IDX_W-1:0] idx;
  logic ready;
  logic in_data, is_time, tk_wr, ctl_wr;
  nib_t ctl_a, ctl_b, ctl_c, ctl_pick;
  logic freeze, stop, clr_sec, h24, step;
  tbank_t time_q, vis_q;

  assign en_wr   = bus_wr && bus_sel == SEL_EN;
  assign data_wr = bus_wr && bus_sel == SEL_DATA;
  assign data_rd = bus_rd && bus_sel == SEL_DATA;

  rtc_port_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_wr  (en_wr),
    .data_wr(data_wr),
    .data_rd(data_rd),
    .wdata  (bus_wdata),
    .phase  (phase),
    .idx    (idx),
    .ready  (ready)
  );

  assign in_data = phase == PH_DATA;
  assign is_time = idx <= R_DOW;
  assign tk_wr   = data_wr && in_data && is_time;
  assign ctl_wr  = data_wr && in_data && !is_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a <= CA_RST;
      ctl_b <= CB_RST;
      ctl_c <= CC_RST;
    end else if (ctl_wr) begin
      case (idx)
        R_CA:    ctl_a <= bus_wdata[NIB_W-1:0];
        R_CB:    ctl_b <= bus_wdata[NIB_W-1:0];
        default: ctl_c <= bus_wdata[NIB_W-1:0];
      endcase
    end
  end

  assign freeze  = ctl_a[0];
  assign clr_sec = ctl_c[0];
  assign stop    = ctl_c[1];
  assign h24     = ctl_c[2];

  rtc_timekeeper u_tk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sec_tick),
    .stop   (stop),
    .clr_sec(clr_sec),
    .h24    (h24),
    .wr_en  (tk_wr),
    .wr_idx (idx),
    .wr_nib (bus_wdata[NIB_W-1:0]),
    .time_q (time_q),
    .step   (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vis_q <= epoch_bank();
    else if (!freeze) vis_q <= time_q;
  end

  always_comb begin
    ctl_pick = (idx == R_CA) ? ctl_a : (idx == R_CB) ? ctl_b : ctl_c;
    bus_rdata = '0;
    case (bus_sel)
      SEL_EN:   bus_rdata = {{(BUS_W-1){1'b0}}, phase != PH_OFF};
      SEL_DATA: if (in_data) bus_rdata = {{(BUS_W-NIB_W){1'b0}}, is_time ? vis_q[idx] : ctl_pick};
      SEL_STAT: bus_rdata = {ready, {(BUS_W-1){1'b0}}};
      default:  bus_rdata = '0;
    endcase
  end

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(vis_q));

  // R8
  frozen_tick_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && step) |=> time_q != vis_q);
endmodule

// File: tb/bcd_rtc_port_test.sv
module bcd_rtc_port_test;
  typedef logic [3:0] tv_t [13];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  bcd_rtc_port uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // monitor: pops the expected item for each read strobe
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    #1;
    if (bus_rd) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: read without expectation, actual %02h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_rd = 1'b0; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] e, input string t);
    bus_sel = s; bus_wr = 1'b0; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_idx(input logic [3:0] k);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03);
    wr(2'd1, {4'h0, k});
  endtask

  task automatic set_time(input tv_t v);
    set_idx(4'd0);
    for (int i = 0; i < 13; i++) wr(2'd1, {4'h0, v[i]});
  endtask

  task automatic check_time(input tv_t v, input string t);
    set_idx(4'd0);
    for (int i = 0; i < 13; i++) rd(2'd1, {4'h0, v[i]}, t);
  endtask

  task automatic set_ctrl(input logic [3:0] a, input logic [3:0] c);
    set_idx(4'd13);
    wr(2'd1, {4'h0, a});
    wr(2'd1, 8'h0F);
    wr(2'd1, {4'h0, c});
  endtask

  function automatic logic [7:0] reset_val(input int i);
    case (i)
      6, 8, 13: return 8'h01;
      14:       return 8'h0F;
      15:       return 8'h06;
      default:  return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, port off
    rd(2'd0, 8'h00, "R1 enable off at reset");
    rd(2'd2, 8'h00, "R11 status off");
    rd(2'd1, 8'h00, "R1 data read while off");
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h01, "R1 enable on");
    rd(2'd2, 8'h00, "R11 status in command step");
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h00);
    rd(2'd2, 8'h80, "R11 status ready in data step");
    // R4 reset values, R3 auto-increment and wrap 15 -> 0
    for (int i = 0; i < 16; i++) rd(2'd1, reset_val(i), "R4 reset value");
    rd(2'd1, 8'h00, "R3 index wrap to 0");

    // run, 24-hour mode
    set_ctrl(4'h0, 4'h4);
    set_time('{4'd8,4'd5,4'd9,4'd5,4'd3,4'd2,4'd1,4'd3,4'd2,4'd1,4'd9,4'd9,4'd6});
    tick();
    set_idx(4'd0);
    rd(2'd1, 8'h09, "R5 seconds ones step");
    rd(2'd1, 8'h05, "R5 seconds tens");
    tick();
    check_time('{4'd0,4'd0,4'd0,4'd0,4'd0,4'd0,4'd1,4'd0,4'd1,4'd0,4'd0,4'd0,4'd0}, "R5 R6 full rollover");
    set_idx(4'd15);
    rd(2'd1, 8'h04, "R3 control C readback");
    rd(2'd1, 8'h00, "R3 wrap after index 15");

    // R6 month lengths
    set_time('{4'd9,4'd5,4'd9,4'd5,4'd3,4'd2,4'd8,4'd2,4'd2,4'd0,4'd4,4'd2,4'd1});
    tick();
    check_time('{4'd0,4'd0,4'd0,4'd0,4'd0,4'd0,4'd9,4'd2,4'd2,4'd0,4'd4,4'd2,4'd2}, "R6 leap February");
    set_time('{4'd9,4'd5,4'd9,4'd5,4'd3,4'd2,4'd8,4'd2,4'd2,4'd0,4'd3,4'd2,4'd1});
    tick();
    check_time('{4'd0,4'd0,4'd0,4'd0,4'd0,4'd0,4'd1,4'd0,4'd3,4'd0,4'd3,4'd2,4'd2}, "R6 plain February");
    set_time('{4'd9,4'd5,4'd9,4'd5,4'd3,4'd2,4'd0,4'd3,4'd4,4'd0,4'd5,4'd2,4'd1});
    tick();
    check_time('{4'd0,4'd0,4'd0,4'd0,4'd0,4'd0,4'd1,4'd0,4'd5,4'd0,4'd5,4'd2,4'd2}, "R6 30-day month");

    // R7 12-hour mode
    set_ctrl(4'h0, 4'h0);
    set_time('{4'd9,4'd5,4'd9,4'd5,4'd1,4'd1,4'd5,4'd0,4'd3,4'd0,4'd5,4'd2,4'd2});
    tick();
    check_time('{4'd0,4'd0,4'd0,4'd0,4'd2,4'd5,4'd5,4'd0,4'd3,4'd0,4'd5,4'd2,4'd2}, "R7 11 AM to 12 PM");
    set_time('{4'd9,4'd5,4'd9,4'd5,4'd1,4'd5,4'd5,4'd0,4'd3,4'd0,4'd5,4'd2,4'd2});
    tick();
    check_time('{4'd0,4'd0,4'd0,4'd0,4'd2,4'd1,4'd6,4'd0,4'd3,4'd0,4'd5,4'd2,4'd3}, "R7 11 PM to 12 AM");

    // R8 freeze
    set_ctrl(4'h0, 4'h4);
    set_time('{4'd0,4'd0,4'd0,4'd0,4'd0,4'd1,4'd1,4'd0,4'd1,4'd0,4'd0,4'd0,4'd0});
    set_ctrl(4'h1, 4'h4);
    tick();
    tick();
    set_idx(4'd0);
    rd(2'd1, 8'h00, "R8 frozen view");
    set_ctrl(4'h0, 4'h4);
    set_idx(4'd0);
    rd(2'd1, 8'h02, "R8 view after release");

    // R9 stop
    set_ctrl(4'h0, 4'h6);
    tick();
    set_idx(4'd0);
    rd(2'd1, 8'h02, "R9 stopped seconds");
    // R10 stop and clear seconds
    set_ctrl(4'h0, 4'h5);
    tick();
    set_idx(4'd0);
    rd(2'd1, 8'h00, "R10 seconds ones cleared");
    rd(2'd1, 8'h00, "R10 seconds tens cleared");
    rd(2'd1, 8'h00, "R10 minutes kept");

    // R12 disable resets the sequencer, R2 command filtering
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h00, "R1 enable off");
    rd(2'd2, 8'h00, "R11 status while off");
    rd(2'd1, 8'h00, "R1 data read while off");
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h07);
    rd(2'd2, 8'h00, "R2 bad command ignored");
    wr(2'd1, 8'h0C);
    rd(2'd2, 8'h00, "R12 command accepted, index step");
    wr(2'd1, 8'h05);
    rd(2'd2, 8'h80, "R11 ready after index");
    rd(2'd1, 8'h01, "R12 index 5 hours tens");
    rd(2'd2, 8'h00, "R11 ready cleared after read");
    rd(2'd2, 8'h80, "R11 ready set again");

    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule